// File: doc/BRIEF.md
# Sleep-Mode Wake-Up Event Detector

This block watches a single-wire bus transceiver while it sleeps and tells the mode controller when it must wake. It takes two digitised levels: the bus line (1 = recessive, 0 = dominant) and a local wake switch input. Both pass through two-flop synchronisers. A microsecond tick from elsewhere in the chip provides the time base. All filter lengths are counted in ticks.

A remote wake is a complete dominant pulse on the bus. The bus must go from recessive to dominant, stay dominant for at least a minimum number of ticks, and then return to recessive. A local wake needs no particular polarity. When the sleep-entry strobe fires, the synchronised switch level is stored as a reference. Any level opposite to that reference which lasts for the switch filter time counts as a wake, so either a closing or an opening switch works.

The detector runs only while the sleep flag is high. It emits at most one single-cycle pulse per sleep period. On that pulse the mode controller moves to its awake state, raising the inhibit output and pulling the receive line low. Wake through the enable pin is handled in the mode controller and is not part of this block.

Top module: `sleep_wake_detector`

## Requirements
- R1: After reset, `wake_pulse` is 0.
- R2: While asleep, a bus sequence of recessive (1) then dominant (0) then recessive (1) produces a wake pulse when the dominant span counted at least `BUS_MIN_TICKS` ticks. The pulse is high in the third clock cycle after the cycle in which `bus_level` returns to 1.
- R3: A dominant span of fewer than `BUS_MIN_TICKS` ticks produces no wake. Its count does not carry into the next dominant span.
- R4: A dominant level that is still held produces no wake, however long it lasts. The wake follows only its release.
- R5: A bus that is already dominant when sleep is entered produces no wake when it is released, because no recessive-to-dominant edge was seen.
- R6: The synchronised `wake_level` at `sleep_entry` becomes the reference. The opposite level produces a wake on its `PIN_MIN_TICKS`-th tick. This works for both reference polarities. `PIN_MIN_TICKS`-1 ticks produce nothing.
- R7: A switch level that returns to the reference before the filter expires restarts the count from zero.
- R8: No wake is emitted while `in_sleep` is 0. At most one wake is emitted per sleep period. A new `sleep_entry` re-arms the detector.
- R9: `wake_pulse` is high for exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_sleep | input | 1 | High while the interface is in its sleep state |
| sleep_entry | input | 1 | One-cycle strobe on entering sleep; captures the switch reference |
| us_tick | input | 1 | One-cycle microsecond time-base strobe |
| bus_level | input | 1 | Asynchronous digitised bus level, 1 = recessive |
| wake_level | input | 1 | Asynchronous digitised local wake switch level |
| wake_pulse | output | 1 | One-cycle wake request to the mode controller |

## Verification
A bus counter that is stuck or never cleared shows up at the port. A short pulse then wakes the device, or a pulse at exactly the limit does not, and this is visible three cycles after the release. A stale switch reference or a filter that fails to restart gives a pulse on the wrong polarity, or one tick early, and the pulse appears one cycle after that tick. A one-per-period flag that is not cleared shows as a missing pulse in the next sleep period. A flag that never sets shows as a second pulse within one period.

// File: rtl/wkd_pkg.sv
package wkd_pkg;

  // Width of a saturating counter able to hold the value lim.
  function automatic int unsigned cnt_width(int unsigned lim);
    return (lim < 1) ? 1 : $clog2(lim + 1);
  endfunction

  // True once a filter counter has reached its limit.
  function automatic logic filter_done(int unsigned count, int unsigned limit);
    return count >= limit;
  endfunction

  // True when one more tick completes the filter.
  function automatic logic last_tick(int unsigned count, int unsigned limit);
    return (count + 1) == limit;
  endfunction

endpackage

// File: rtl/wkd_sync.sv
module wkd_sync #(
  parameter int unsigned     WIDTH     = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic stage1_q, stage2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1_q <= RESET_VAL[i];
        stage2_q <= RESET_VAL[i];
      end else begin
        stage1_q <= d[i];
        stage2_q <= stage1_q;
      end
    end
    assign q[i] = stage2_q;
  end

endmodule

// File: rtl/wkd_bus_det.sv
module wkd_bus_det #(
  parameter int unsigned MIN_TICKS = 70
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic en,
  input  logic tick,
  input  logic bus_rec,
  output logic hit
);
  import wkd_pkg::*;

  localparam int unsigned CW = cnt_width(MIN_TICKS);

  logic [CW-1:0] span_cnt_q;
  logic          seen_rec_q;
  logic          bus_prev_q;
  logic          release_edge;
  logic          span_long;

  assign release_edge = bus_rec & ~bus_prev_q;
  assign span_long    = filter_done(32'(span_cnt_q), MIN_TICKS);
  assign hit          = en & seen_rec_q & release_edge & span_long;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      span_cnt_q <= '0;
      seen_rec_q <= 1'b0;
      bus_prev_q <= 1'b1;
    end else begin
      bus_prev_q <= bus_rec;
      if (clear) begin
        span_cnt_q <= '0;
        seen_rec_q <= 1'b0;
      end else if (en) begin
        if (bus_rec) begin
          seen_rec_q <= 1'b1;
          span_cnt_q <= '0;
        end else if (seen_rec_q && tick && !span_long) begin
          span_cnt_q <= span_cnt_q + CW'(1);
        end
      end
    end
  end

  // R4: a dominant level still held never reports a wake
  p_bus_held_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rec |-> !hit);

  // R3: the span counter saturates at its limit
  p_bus_cnt_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(span_cnt_q) <= MIN_TICKS);

  // R5: without a recessive level seen since clearing, no wake
  p_bus_needs_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !hit);

endmodule

// File: rtl/wkd_pin_det.sv
module wkd_pin_det #(
  parameter int unsigned MIN_TICKS = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic clear,
  input  logic en,
  input  logic tick,
  input  logic pin,
  output logic hit
);
  import wkd_pkg::*;

  localparam int unsigned CW = cnt_width(MIN_TICKS);

  logic [CW-1:0] hold_cnt_q;
  logic          ref_q;
  logic          changed;
  logic          final_tick;

  assign changed    = pin ^ ref_q;
  assign final_tick = last_tick(32'(hold_cnt_q), MIN_TICKS);
  assign hit        = en & changed & tick & final_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q      <= 1'b0;
      hold_cnt_q <= '0;
    end else begin
      if (capture) ref_q <= pin;
      if (clear) begin
        hold_cnt_q <= '0;
      end else if (en) begin
        if (!changed) begin
          hold_cnt_q <= '0;
        end else if (tick && !final_tick) begin
          hold_cnt_q <= hold_cnt_q + CW'(1);
        end
      end
    end
  end

  // R7: a wake from the switch only completes on a tick
  p_pin_hit_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> tick);

  // R6: the hold counter never passes the filter length
  p_pin_cnt_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(hold_cnt_q) < MIN_TICKS);

  // R6: the reference only moves on a capture strobe
  p_pin_ref_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(ref_q));

endmodule

// File: rtl/sleep_wake_detector.sv
module sleep_wake_detector #(
  parameter int unsigned BUS_MIN_TICKS = 70,
  parameter int unsigned PIN_MIN_TICKS = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_sleep,
  input  logic sleep_entry,
  input  logic us_tick,
  input  logic bus_level,
  input  logic wake_level,
  output logic wake_pulse
);

  logic [1:0] sync_q;
  logic       bus_s, pin_s;
  logic       clear, en;
  logic       bus_hit, pin_hit, any_hit;
  logic       done_q;

  wkd_sync #(.WIDTH(2), .RESET_VAL(2'b10)) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({bus_level, wake_level}),
    .q    (sync_q)
  );

  assign bus_s = sync_q[1];
  assign pin_s = sync_q[0];

  assign clear   = ~in_sleep | sleep_entry;
  assign en      = in_sleep & ~sleep_entry & ~done_q;
  assign any_hit = bus_hit | pin_hit;

  wkd_bus_det #(.MIN_TICKS(BUS_MIN_TICKS)) i_bus (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clear),
    .en     (en),
    .tick   (us_tick),
    .bus_rec(bus_s),
    .hit    (bus_hit)
  );

  wkd_pin_det #(.MIN_TICKS(PIN_MIN_TICKS)) i_pin (
    .clk    (clk),
    .rst_n  (rst_n),
    .capture(sleep_entry),
    .clear  (clear),
    .en     (en),
    .tick   (us_tick),
    .pin    (pin_s),
    .hit    (pin_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_pulse <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      wake_pulse <= any_hit;
      done_q     <= clear ? 1'b0 : (done_q | any_hit);
    end
  end

  // R9: the wake request lasts one cycle
  p_pulse_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  // R8: nothing is requested while awake
  p_no_wake_awake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_sleep |=> !wake_pulse);

  // R8: one request per sleep period
  p_once_per_period_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && in_sleep && !sleep_entry) |=> !wake_pulse);

  // R1: quiet straight out of reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> !wake_pulse);

endmodule

// File: tb/test_sleep_wake_detector.sv
`timescale 1ns/1ps
module test_sleep_wake_detector;

  localparam int unsigned BUS_MIN = 70;
  localparam int unsigned PIN_MIN = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_sleep = 1'b0;
  logic sleep_entry = 1'b0;
  logic us_tick = 1'b0;
  logic bus_level = 1'b1;
  logic wake_level = 1'b0;
  logic wake_pulse;

  int checks = 0;
  int failures = 0;
  int pulses = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sleep_wake_detector #(.BUS_MIN_TICKS(BUS_MIN), .PIN_MIN_TICKS(PIN_MIN)) i_sleep_wake_detector (
    .clk(clk), .rst_n(rst_n), .in_sleep(in_sleep), .sleep_entry(sleep_entry),
    .us_tick(us_tick), .bus_level(bus_level), .wake_level(wake_level),
    .wake_pulse(wake_pulse)
  );

  always @(posedge clk) if (wake_pulse) pulses <= pulses + 1;

  typedef struct packed {
    logic       from_pin;
    logic       ref_lvl;
    logic [7:0] ticks;
    logic       expect_wake;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 1'b0, 8'd70,  1'b1},   // R2 bus exactly at limit
    '{1'b0, 1'b0, 8'd69,  1'b0},   // R3 bus one tick short
    '{1'b0, 1'b1, 8'd100, 1'b1},   // R2 bus long
    '{1'b0, 1'b0, 8'd20,  1'b0},   // R3 bus very short
    '{1'b1, 1'b0, 8'd40,  1'b1},   // R6 rising change
    '{1'b1, 1'b1, 8'd40,  1'b1},   // R6 falling change
    '{1'b1, 1'b0, 8'd39,  1'b0},   // R6 one tick short
    '{1'b1, 1'b1, 8'd10,  1'b0}    // R6 short
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick_n(input int n);
    repeat (n) begin
      us_tick = 1'b1;
      @(negedge clk);
      us_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic enter_sleep(input logic ref_lvl);
    in_sleep = 1'b0;
    idle(3);
    wake_level = ref_lvl;
    bus_level = 1'b1;
    idle(4);
    sleep_entry = 1'b1;
    in_sleep = 1'b1;
    idle(1);
    sleep_entry = 1'b0;
    idle(3);
  endtask

  task automatic bus_span(input int n);
    bus_level = 1'b0;
    idle(3);
    tick_n(n);
    bus_level = 1'b1;
    idle(6);
  endtask

  task automatic pin_span(input logic lvl, input int n);
    wake_level = lvl;
    idle(3);
    tick_n(n);
    idle(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R9 watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int base;
    idle(3);
    chk("R1 pulse in reset", int'(wake_pulse), 0);
    rst_n = 1'b1;
    idle(5);
    chk("R1 pulse after reset", int'(wake_pulse), 0);

    // Table walk
    foreach (VEC[i]) begin
      enter_sleep(VEC[i].ref_lvl);
      base = pulses;
      if (VEC[i].from_pin) pin_span(~VEC[i].ref_lvl, int'(VEC[i].ticks));
      else                 bus_span(int'(VEC[i].ticks));
      chk(VEC[i].from_pin ? "R6 table pin wake" : "R2/R3 table bus wake",
          pulses - base, int'(VEC[i].expect_wake));
    end

    // R2 exact latency, R9 width
    enter_sleep(1'b0);
    bus_level = 1'b0;
    idle(3);
    tick_n(BUS_MIN);
    bus_level = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk("R2 no pulse before third cycle", int'(wake_pulse), 0);
    @(posedge clk); @(negedge clk);
    chk("R2 pulse in third cycle", int'(wake_pulse), 1);
    @(negedge clk);
    chk("R9 pulse one cycle wide", int'(wake_pulse), 0);

    // R4 held dominant
    enter_sleep(1'b0);
    base = pulses;
    bus_level = 1'b0;
    idle(3);
    tick_n(100);
    idle(20);
    chk("R4 held dominant silent", pulses - base, 0);
    bus_level = 1'b1;
    idle(6);
    chk("R4 wake on release", pulses - base, 1);

    // R5 dominant already at entry
    in_sleep = 1'b0;
    idle(3);
    bus_level = 1'b0;
    wake_level = 1'b0;
    idle(4);
    sleep_entry = 1'b1; in_sleep = 1'b1;
    idle(1);
    sleep_entry = 1'b0;
    base = pulses;
    idle(3);
    tick_n(100);
    bus_level = 1'b1;
    idle(6);
    chk("R5 no edge no wake", pulses - base, 0);

    // R3 short spans do not accumulate
    enter_sleep(1'b0);
    base = pulses;
    bus_span(60);
    bus_span(60);
    chk("R3 short spans no accumulation", pulses - base, 0);
    bus_span(BUS_MIN);
    chk("R3 full span after short ones", pulses - base, 1);

    // R7 restart of switch filter
    enter_sleep(1'b0);
    base = pulses;
    pin_span(1'b1, PIN_MIN - 1);
    pin_span(1'b0, 2);
    pin_span(1'b1, PIN_MIN - 1);
    chk("R7 restart after revert", pulses - base, 0);
    tick_n(1);
    idle(4);
    chk("R7 wake on completed filter", pulses - base, 1);

    // R8 not in sleep
    in_sleep = 1'b0;
    idle(4);
    base = pulses;
    bus_span(100);
    pin_span(1'b0, 60);
    chk("R8 no wake while awake", pulses - base, 0);

    // R8 once per period, re-arm
    enter_sleep(1'b0);
    base = pulses;
    pin_span(1'b1, PIN_MIN);
    bus_span(BUS_MIN + 10);
    pin_span(1'b0, PIN_MIN + 5);
    chk("R8 one wake per period", pulses - base, 1);
    enter_sleep(1'b1);
    pin_span(1'b0, PIN_MIN);
    chk("R8 re-armed by new entry", pulses - base, 2);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule